// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of an 8051-compatible core and turns push and pop requests into stack memory addresses. The pointer is 11 bits wide: an 8-bit low byte and a 3-bit high extension. Both halves are special function registers (SFRs) that the core can read and write. A push or call increments the pointer before its data is written. A pop or return reads at the current pointer and then decrements it.

A run-time enable bit in a configuration SFR picks the mode. With the bit clear, the stack is the classic 8-bit one. It wraps within the 256-byte internal RAM, and the high extension register is hidden. With the bit set, the pointer behaves as a full 11-bit counter. Addresses of 0100h and above go to the upper part of the 2 KB on-chip extended RAM.

Beside the address, the block drives a select line that tells the core which memory to use. The stack memories, the instruction decode and the interrupt logic sit outside this block. They reach it only as push, pop and SFR access strobes.

Top module: `xsp_unit`

## Requirements
- R1: After reset, the low pointer byte is 07h, the high pointer bits are 0 and the configuration register reads 00h. The first push therefore addresses 008h.
- R2: During a push cycle, `stk_addr_o` shows the incremented pointer. After the clock edge, the pointer holds that value.
- R3: During a pop cycle, `stk_addr_o` shows the current pointer. After the clock edge, the pointer is one lower.
- R4: With the enable clear, a push from FFh goes to 00h and a pop from 00h goes to FFh. The high pointer bits stay 0.
- R5: With the enable set, the pointer counts over 11 bits. A push from 0FFh gives 100h, and a pop from 100h gives 0FFh. A push from 7FFh gives 000h, and a pop from 000h gives 7FFh.
- R6: `stk_xram_o` is 1 exactly when `stk_addr_o` is 100h or higher. Outside a push or pop, `stk_addr_o` shows the pointer.
- R7: The SFR map works as follows.
  - Address 81h reads and writes the low byte.
  - Address AFh is the configuration register. Its bit 7 is the enable, and its other bits read 0.
  - With the enable set, address B7h reads the 3 high bits in bits 2:0 with zeros above them. A write to B7h loads bits 2:0.
  - Any other address reads 00h.
- R8: With the enable clear, a read of B7h returns 00h and a write to B7h has no effect on the pointer.
- R9: Writing the enable to 0 clears the 3 high pointer bits. They read 0 after the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push or call strobe, one cycle per byte |
| pop_i | input | 1 | Pop or return strobe, one cycle per byte |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address for read and write |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for `sfr_addr_i` (combinational) |
| stk_addr_o | output | 11 | Stack memory address for this cycle |
| stk_xram_o | output | 1 | 1: the address is in extended RAM, 0: the address is in internal RAM |
| ext_en_o | output | 1 | Current state of the extend enable |

## Verification
The assertions take for granted that the core never raises more than one of push, pop and SFR write in the same cycle. The first checker property states that assumption. The stimulus keeps to it: each bench step drives at most one strobe, including the long mixed sequence that draws its operation from a single pick. Beyond that single-strobe rule, SFR addresses and data are left unconstrained, so writes to unmapped addresses and to the hidden high register are part of the stimulus.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 3;
  localparam int SP_W  = LO_W + HI_W;
  localparam int SFR_W = 8;

  typedef logic [SP_W-1:0] sp_t;

  // next pointer for a push: full carry when wide, low-byte wrap otherwise
  function automatic sp_t sp_step_up(sp_t sp, logic wide);
    logic [LO_W-1:0] lo;
    if (wide) return sp + SP_W'(1);
    lo = sp[LO_W-1:0] + LO_W'(1);
    return {{HI_W{1'b0}}, lo};
  endfunction

  // next pointer for a pop: full borrow when wide, low-byte wrap otherwise
  function automatic sp_t sp_step_down(sp_t sp, logic wide);
    logic [LO_W-1:0] lo;
    if (wide) return sp - SP_W'(1);
    lo = sp[LO_W-1:0] - LO_W'(1);
    return {{HI_W{1'b0}}, lo};
  endfunction
endpackage

// File: rtl/xsp_sfr_dec.sv
module xsp_sfr_dec
  import xsp_pkg::*;
#(
  parameter logic [SFR_W-1:0] LO_ADDR  = 8'h81,
  parameter logic [SFR_W-1:0] HI_ADDR  = 8'hB7,
  parameter logic [SFR_W-1:0] CFG_ADDR = 8'hAF,
  parameter int               EN_BIT   = 7
) (
  input  logic             sfr_wr_i,
  input  logic [SFR_W-1:0] sfr_addr_i,
  input  sp_t              sp,
  input  logic             ext_en,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic             wr_cfg,
  output logic [SFR_W-1:0] rdata
);
  localparam int PAD_W = SFR_W - HI_W;

  logic hit_lo, hit_hi, hit_cfg;
  assign hit_lo  = (sfr_addr_i == LO_ADDR);
  assign hit_hi  = (sfr_addr_i == HI_ADDR);
  assign hit_cfg = (sfr_addr_i == CFG_ADDR);

  assign wr_lo  = sfr_wr_i & hit_lo;
  assign wr_hi  = sfr_wr_i & hit_hi & ext_en;   // hidden while narrow
  assign wr_cfg = sfr_wr_i & hit_cfg;

  always_comb begin
    rdata = '0;
    if (hit_lo)
      rdata = sp[LO_W-1:0];
    else if (hit_hi && ext_en)
      rdata = {{PAD_W{1'b0}}, sp[SP_W-1:LO_W]};
    else if (hit_cfg)
      rdata[EN_BIT] = ext_en;
  end
endmodule

// File: rtl/xsp_ptr_core.sv
module xsp_ptr_core
  import xsp_pkg::*;
#(
  parameter int              EN_BIT   = 7,
  parameter logic [LO_W-1:0] RESET_LO = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_cfg,
  input  logic [SFR_W-1:0] wdata,
  output sp_t              sp_q,
  output logic             ext_en_q
);
  // SFR writes take priority over stack strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q     <= {{HI_W{1'b0}}, RESET_LO};
      ext_en_q <= 1'b0;
    end else if (wr_cfg) begin
      ext_en_q <= wdata[EN_BIT];
      if (!wdata[EN_BIT]) sp_q[SP_W-1:LO_W] <= '0;
    end else if (wr_lo) begin
      sp_q[LO_W-1:0] <= wdata[LO_W-1:0];
    end else if (wr_hi) begin
      sp_q[SP_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (push) begin
      sp_q <= sp_step_up(sp_q, ext_en_q);
    end else if (pop) begin
      sp_q <= sp_step_down(sp_q, ext_en_q);
    end
  end
endmodule

// File: rtl/xsp_addr_gen.sv
module xsp_addr_gen
  import xsp_pkg::*;
(
  input  sp_t  sp,
  input  logic ext_en,
  input  logic push,
  output sp_t  addr,
  output logic xram_sel
);
  assign addr     = push ? sp_step_up(sp, ext_en) : sp;
  assign xram_sel = |addr[SP_W-1:LO_W];
endmodule

// File: rtl/xsp_unit.sv
module xsp_unit
  import xsp_pkg::*;
#(
  parameter logic [SFR_W-1:0] LO_ADDR  = 8'h81,
  parameter logic [SFR_W-1:0] HI_ADDR  = 8'hB7,
  parameter logic [SFR_W-1:0] CFG_ADDR = 8'hAF,
  parameter int               EN_BIT   = 7,
  parameter logic [LO_W-1:0]  RESET_LO = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             sfr_wr_i,
  input  logic [SFR_W-1:0] sfr_addr_i,
  input  logic [SFR_W-1:0] sfr_wdata_i,
  output logic [SFR_W-1:0] sfr_rdata_o,
  output logic [SP_W-1:0]  stk_addr_o,
  output logic             stk_xram_o,
  output logic             ext_en_o
);
  sp_t  sp_q;
  logic ext_en_q;
  logic wr_lo, wr_hi, wr_cfg;

  xsp_sfr_dec #(
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CFG_ADDR(CFG_ADDR), .EN_BIT(EN_BIT)
  ) u_dec (
    .sfr_wr_i  (sfr_wr_i),
    .sfr_addr_i(sfr_addr_i),
    .sp        (sp_q),
    .ext_en    (ext_en_q),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_cfg    (wr_cfg),
    .rdata     (sfr_rdata_o)
  );

  xsp_ptr_core #(.EN_BIT(EN_BIT), .RESET_LO(RESET_LO)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push_i),
    .pop     (pop_i),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_cfg  (wr_cfg),
    .wdata   (sfr_wdata_i),
    .sp_q    (sp_q),
    .ext_en_q(ext_en_q)
  );

  xsp_addr_gen u_addr (
    .sp      (sp_q),
    .ext_en  (ext_en_q),
    .push    (push_i),
    .addr    (stk_addr_o),
    .xram_sel(stk_xram_o)
  );

  assign ext_en_o = ext_en_q;
endmodule

// File: rtl/xsp_unit_chk.sv
module xsp_unit_chk
  import xsp_pkg::*;
#(
  parameter logic [SFR_W-1:0] HI_ADDR = 8'hB7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic             sfr_wr_i,
  input logic [SFR_W-1:0] sfr_addr_i,
  input logic [SFR_W-1:0] sfr_rdata_o,
  input logic [SP_W-1:0]  stk_addr_o,
  input logic             stk_xram_o,
  input logic             ext_en_o,
  input sp_t              sp_q
);
  p_one_strobe_in: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_i, pop_i, sfr_wr_i}));

  p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> sp_q == $past(stk_addr_o));

  p_pop_at_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> stk_addr_o == sp_q);

  p_narrow_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_o |-> sp_q[SP_W-1:LO_W] == '0);

  p_narrow_no_xram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_o |-> !stk_xram_o);

  p_hidden_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en_o && sfr_addr_i == HI_ADDR) |-> sfr_rdata_o == '0);

  p_hidden_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr_i && sfr_addr_i == HI_ADDR && !ext_en_o) |=> $stable(sp_q));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_en_o) |-> sp_q[SP_W-1:LO_W] == '0);
endmodule

bind xsp_unit xsp_unit_chk #(.HI_ADDR(HI_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .sfr_wr_i   (sfr_wr_i),
  .sfr_addr_i (sfr_addr_i),
  .sfr_rdata_o(sfr_rdata_o),
  .stk_addr_o (stk_addr_o),
  .stk_xram_o (stk_xram_o),
  .ext_en_o   (ext_en_o),
  .sp_q       (sp_q)
);

// File: tb/xsp_unit_tb_top.sv
`timescale 1ns/1ps
module xsp_unit_tb_top;
  localparam time HALF = 10ns;   // 50 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, sfr_wr_i = 1'b0;
  logic [7:0] sfr_addr_i = 8'h00, sfr_wdata_i = 8'h00;
  logic [7:0] sfr_rdata_o;
  logic [10:0] stk_addr_o;
  logic       stk_xram_o, ext_en_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_ptr;
  bit m_wide;

  always #HALF clk = ~clk;

  xsp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o), .stk_addr_o(stk_addr_o),
    .stk_xram_o(stk_xram_o), .ext_en_o(ext_en_o)
  );

  function automatic int bump(int p, bit wide, int d);
    if (wide) return (p + d + 2048) % 2048;
    return (p + d + 256) % 256;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, compare, then advance the model
  task automatic step(string tag, bit ps, bit pp, bit wr, int adr, int dat);
    int exp_addr, exp_rd;
    @(negedge clk);
    push_i = ps; pop_i = pp; sfr_wr_i = wr;
    sfr_addr_i = 8'(adr); sfr_wdata_i = 8'(dat);
    #2;
    exp_addr = ps ? bump(m_ptr, m_wide, 1) : m_ptr;
    case (adr)
      'h81:    exp_rd = m_ptr % 256;
      'hB7:    exp_rd = m_wide ? m_ptr / 256 : 0;
      'hAF:    exp_rd = m_wide ? 'h80 : 0;
      default: exp_rd = 0;
    endcase
    check(tag, "stk_addr", int'(stk_addr_o), exp_addr);
    check(tag, "xram_sel", int'(stk_xram_o), (exp_addr >= 256) ? 1 : 0);
    check(tag, "rdata", int'(sfr_rdata_o), exp_rd);
    check(tag, "ext_en", int'(ext_en_o), int'(m_wide));
    @(posedge clk);
    if (wr) begin
      if (adr == 'h81) m_ptr = (m_ptr / 256) * 256 + (dat % 256);
      else if (adr == 'hB7 && m_wide) m_ptr = (dat % 8) * 256 + m_ptr % 256;
      else if (adr == 'hAF) begin
        m_wide = dat[7];
        if (!m_wide) m_ptr = m_ptr % 256;
      end
    end else if (ps) m_ptr = bump(m_ptr, m_wide, 1);
    else if (pp) m_ptr = bump(m_ptr, m_wide, -1);
  endtask

  task automatic idle(string tag, int adr); step(tag, 0, 0, 0, adr, 0); endtask
  task automatic wr(string tag, int adr, int dat); step(tag, 0, 0, 1, adr, dat); endtask
  task automatic push(string tag); step(tag, 1, 0, 0, 'h81, 0); endtask
  task automatic pop(string tag); step(tag, 0, 1, 0, 'h81, 0); endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_ptr = 'h07; m_wide = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    idle("R1", 'h81); idle("R1", 'hAF); idle("R1", 'hB7);
    push("R1");
    // R2 / R3 basic push and pop
    push("R2"); push("R2"); pop("R3"); pop("R3"); idle("R3", 'h81);
    // R4 narrow wrap both ways
    wr("R4", 'h81, 'hFE); push("R4"); push("R4"); idle("R4", 'hB7);
    pop("R4"); idle("R4", 'h81);
    // R8 hidden high register
    wr("R8", 'hB7, 'h05); idle("R8", 'hB7); push("R8");
    // R7 enable and map
    wr("R7", 'hAF, 'hFF); idle("R7", 'hAF);
    wr("R5", 'h81, 'hFE); push("R5"); push("R6"); idle("R6", 'hB7);
    pop("R5"); idle("R5", 'h81);
    wr("R7", 'hB7, 'h07); idle("R7", 'hB7);
    wr("R5", 'h81, 'hFF); push("R5"); idle("R5", 'h81);
    pop("R5"); idle("R5", 'hB7);
    wr("R7", 'hB7, 'hFB); idle("R7", 'hB7); idle("R7", 'h80); idle("R7", 'h00);
    // R9 disable clears high bits
    wr("R9", 'hAF, 'h7F); idle("R9", 'h81); push("R9");
    wr("R9", 'hAF, 'h80); idle("R9", 'hB7);

    // mixed run, one strobe at most per cycle
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int d  = $urandom_range(0, 255);
      case (op)
        0, 1, 2: push("R6");
        3, 4:    pop("R6");
        5:       wr("R7", 'h81, d);
        6:       wr("R7", 'hB7, d);
        7:       wr("R9", 'hAF, ($urandom_range(0, 3) != 0) ? (d | 'h80) : (d & 'h7F));
        8:       wr("R7", $urandom_range(0, 255), d);
        default: idle("R6", ($urandom_range(0, 1) != 0) ? 'hB7 : 'hAF);
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule